// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one burst request into the sequence of column addresses that a synchronous DRAM controller presents beat by beat. A single-cycle start pulse captures an 8-bit column start address, a burst length code and an ordering select. From the following cycle onward, the block emits one column address per clock. It also flags the final beat of any finite burst.

Two orderings are supported. Sequential ordering wraps inside the aligned block of burst size. Interleaved ordering XORs the beat number into the low address bits. A full-page burst walks every column of the row, wraps from the top column back to zero, and keeps going until a terminate pulse stops it. When a write-single option is set, a write request is cut to one beat while reads keep the programmed length. Data movement, command sequencing and latency alignment belong to other blocks.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset, `col_valid` and `col_last` are low, and they stay low until a start pulse is sampled.
- R2: When `start` is sampled high, the next cycle shows `col_valid`=1 and `col`=`start_col`. Length, ordering and write-single settings are latched at start, so changes to them during a burst have no effect.
- R3: `len_code` encoding: 0 gives 1 beat, 1 gives 2 beats, 2 gives 4 beats, 3 gives 8 beats, and 7 gives full page. Codes 4, 5 and 6 give 1 beat.
- R4: With `interleave`=0 and a finite length BL, beat n has column (start & ~(BL-1)) | ((start+n) mod BL). The bits above log2(BL) stay fixed.
- R5: With `interleave`=1 and a finite length BL, beat n has column start XOR n, where n < BL.
- R6: In full page mode, beat n has column (start+n) mod 256, so column 255 is followed by 0. `col_last` never rises, the burst runs until terminated, and `interleave` is ignored.
- R7: `col_last` is high exactly on the final beat of a finite burst. `col_valid` falls in the next cycle unless a new start is sampled.
- R8: If `stop` is sampled high during a burst with no start, `col_valid` is low in the next cycle. If `stop` is sampled while idle, it has no effect.
- R9: If `wr_single`=1 and `is_write`=1 at start, the burst has exactly one beat, whatever `len_code` is. A read (`is_write`=0) keeps the programmed length.
- R10: A start pulse during a burst restarts the sequence: the next cycle is beat 0 of the new request. Start takes precedence over a `stop` pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a burst (one-cycle pulse) |
| stop | input | 1 | Terminate the running burst |
| start_col | input | 8 | Column start address |
| len_code | input | 3 | Burst length code (see R3) |
| interleave | input | 1 | 1 selects interleaved ordering |
| wr_single | input | 1 | 1 limits write bursts to a single beat |
| is_write | input | 1 | Request is a write |
| col | output | 8 | Current column address |
| col_valid | output | 1 | `col` carries a beat |
| col_last | output | 1 | Final beat of a finite burst |

## Verification
The bench aims at the places where the ordering rules are easiest to get wrong:
- **Sequential wrap from a start that is not aligned.** A design that carries into the upper bits would step out of the aligned block. For example, 0x2F would be followed by 0x30 instead of 0x2C.
- **Interleaved bursts from odd starts.** A design that adds instead of XORing would give 0x2E after 0x2D instead of 0x2C.
- **Full-page runs past column 255.** A design that stops at the top column, or raises `col_last` there, would end the burst early.
- **Reserved length codes, write-single cut-off, terminate while idle or mid-burst, and restart or start-versus-stop collisions.** A wrong priority or a missed latch shows up as an extra beat, a missing beat, or a wrong column.

// File: rtl/sdram_col_seq.sv
module sdram_col_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_code,
  input  logic             interleave,
  input  logic             wr_single,
  input  logic             is_write,
  output logic [COL_W-1:0] col,
  output logic             col_valid,
  output logic             col_last
);
  localparam logic [COL_W-1:0] ALL_ONES = '1;

  logic             busy_q, full_q, ilv_q;
  logic [COL_W-1:0] base_q, cnt_q, mask_q;
  logic [COL_W-1:0] mask_d;
  logic             full_d;

  always_comb begin
    full_d = 1'b0;
    mask_d = '0;
    if (!(wr_single && is_write)) begin
      case (len_code)
        3'd1: mask_d = COL_W'(1);
        3'd2: mask_d = COL_W'(3);
        3'd3: mask_d = COL_W'(7);
        3'd7: begin
          full_d = 1'b1;
          mask_d = ALL_ONES;
        end
        default: mask_d = '0;
      endcase
    end
  end

  wire [COL_W-1:0] step_sum = base_q + cnt_q;
  wire             at_end   = !full_q && (cnt_q == mask_q);

  assign col = ilv_q ? (base_q ^ (cnt_q & mask_q))
                     : ((base_q & ~mask_q) | (step_sum & mask_q));
  assign col_valid = busy_q;
  assign col_last  = busy_q && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      mask_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      full_q <= full_d;
      ilv_q  <= interleave && !full_d;
      base_q <= start_col;
      cnt_q  <= '0;
      mask_q <= mask_d;
    end else if (busy_q) begin
      if (stop || at_end) busy_q <= 1'b0;
      else                cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sdram_col_seq_chk.sv
module sdram_col_seq_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             stop,
  input logic [COL_W-1:0] start_col,
  input logic [COL_W-1:0] col,
  input logic             col_valid,
  input logic             col_last
);
  assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_valid && !start) |=> !col_valid);

  assert_start_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (col_valid && col == $past(start_col)));

  assert_last_in_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);

  assert_end_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (col_last && !start) |=> !col_valid);

  assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && stop && !start) |=> !col_valid);

  assert_start_over_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && stop) |=> col_valid);
endmodule

bind sdram_col_seq sdram_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
  .start_col(start_col), .col(col), .col_valid(col_valid), .col_last(col_last)
);

// File: tb/sdram_col_seq_tb.sv
module sdram_col_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, stop = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] len_code = '0;
  logic       interleave = 1'b0, wr_single = 1'b0, is_write = 1'b0;
  logic [7:0] col;
  logic       col_valid, col_last;

  int checks = 0;
  int failures = 0;
  string tag = "R1";

  int m_busy = 0, m_base = 0, m_n = 0, m_len = 1, m_ilv = 0;

  always #5 clk = ~clk;

  sdram_col_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .start_col(start_col), .len_code(len_code), .interleave(interleave),
    .wr_single(wr_single), .is_write(is_write),
    .col(col), .col_valid(col_valid), .col_last(col_last)
  );

  function automatic int beats(input int code, input bit ws, input bit wr);
    if (ws && wr) return 1;
    if (code <= 3) return 1 << code;
    if (code == 7) return 0;
    return 1;
  endfunction

  function automatic int exp_col();
    int off;
    if (m_len == 0) return (m_base + m_n) % 256;
    if (m_ilv != 0) return m_base ^ m_n;
    off = m_base % m_len;
    return (m_base - off) + ((off + m_n) % m_len);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_busy <= 0;
    else if (start) begin
      m_busy <= 1;
      m_base <= int'(start_col);
      m_n    <= 0;
      m_len  <= beats(int'(len_code), wr_single, is_write);
      m_ilv  <= (interleave && beats(int'(len_code), wr_single, is_write) != 0) ? 1 : 0;
    end else if (m_busy != 0) begin
      if (stop || (m_len != 0 && m_n == m_len - 1)) m_busy <= 0;
      else m_n <= m_n + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit ev, el;
      ev = (m_busy != 0);
      el = ev && m_len != 0 && m_n == m_len - 1;
      checks++;
      if (col_valid !== ev || col_last !== el) begin
        failures++;
        $display("FAIL %s valid/last got %b/%b expected %b/%b", tag, col_valid, col_last, ev, el);
      end
      if (ev) begin
        checks++;
        if (int'(col) != exp_col()) begin
          failures++;
          $display("FAIL %s col got %0h expected %0h", tag, col, exp_col());
        end
      end
    end
  end

  task automatic go(input int c, input int code, input bit ilv, input bit ws, input bit wr);
    @(posedge clk); #1;
    start = 1'b1; start_col = 8'(c); len_code = 3'(code);
    interleave = ilv; wr_single = ws; is_write = wr;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 20 && m_busy != 0; i++) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (col_valid !== 1'b0 || col_last !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset got %b/%b expected 0/0", col_valid, col_last);
    end
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    tag = "R3"; for (int c = 0; c < 8; c++) begin go(8'h5A, c, 0, 0, 0); if (c == 7) begin repeat (5) @(posedge clk); #1; stop = 1; @(posedge clk); #1; stop = 0; end drain(); end
    tag = "R4"; go(8'h2D, 2, 0, 0, 0); drain(); go(8'h2F, 3, 0, 0, 0); drain(); go(8'hFF, 1, 0, 0, 0); drain();
    tag = "R5"; go(8'h2D, 3, 1, 0, 0); drain(); go(8'h13, 2, 1, 0, 0); drain(); go(8'h81, 1, 1, 0, 0); drain();
    tag = "R6";
    go(8'hF0, 7, 1, 0, 0);
    repeat (290) @(posedge clk);
    #1; stop = 1; @(posedge clk); #1; stop = 0;
    drain();
    tag = "R2";
    go(8'h40, 3, 0, 0, 0);
    #1; len_code = 3'd0; interleave = 1; start_col = 8'hAA; wr_single = 1; is_write = 1;
    drain();
    tag = "R9"; go(8'h33, 3, 0, 1, 1); drain(); go(8'h33, 3, 0, 1, 0); drain(); go(8'h34, 7, 0, 1, 1); drain();
    tag = "R8";
    #1; stop = 1; repeat (3) @(posedge clk); #1; stop = 0;
    go(8'h10, 3, 0, 0, 0); @(posedge clk); #1; stop = 1; @(posedge clk); #1; stop = 0;
    drain();
    tag = "R10";
    go(8'h20, 3, 0, 0, 0); @(posedge clk);
    go(8'h67, 2, 1, 0, 0); drain();
    go(8'h08, 3, 0, 0, 0); @(posedge clk); #1;
    start = 1; stop = 1; start_col = 8'h91; len_code = 3'd2; interleave = 0;
    @(posedge clk); #1; start = 0; stop = 0;
    drain();
    tag = "R7"; go(8'h07, 3, 0, 0, 0); drain(); go(8'h00, 0, 0, 0, 0); drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule